// File: doc/BRIEF.md
# Receive Status Register with Modem Control

This block is the receive-side control and status word of one asynchronous terminal line. The CPU writes it with whole words or single bytes and reads it, and each read clears the completion and error flags. Three line events come from the serial and transport side: a caller connecting, a caller dropping and a character arriving. The block keeps a private connected flag. It drives a clear-to-send level toward the transmit half of the line, a one-cycle interrupt strobe and a one-cycle hangup request.

A `modem_mode` input picks one of two behaviours. In hardwired mode a connect only raises clear-to-send, and data-terminal-ready is a plain storage bit. In modem mode the block runs a dataset handshake. Connects, disconnects and changes of data-terminal-ready move the carrier-detect, ring and carrier-change flags. A drop of data-terminal-ready during a call requests a hangup. All inputs that arrive in the same cycle are applied in a fixed order: the CPU write first, then connect, then disconnect, then the received character, and the read-and-clear last.

Top module: `rx_status_reg`

## Requirements
- R1: A synchronous reset clears the status word, read data, clear-to-send, the connected flag and both strobes to 0.
- R2: A word write changes only the writable bits 0, 1, 3, 4, 6, 8, 9 and 10, with DTR at bit 0, break at bit 1 and IE at bit 6. All other bits keep their value.
- R3: A byte write takes `wr_data[7:0]`. With `wr_hi`=1 it replaces the high byte, otherwise the low byte, and the writable-bit mask still applies. The other byte is unchanged.
- R4: A read returns the word on `rd_data` one cycle later, with bit 11 forced to 0. Bit 15 of the returned word is 1 exactly when overrun (bit 12), ring (bit 13) or carrier change (bit 14) is set. The read then clears DONE (bit 7) and bits 12 to 15.
- R5: In modem mode, a write that raises DTR while connected clears ring and sets carrier detect (bit 2), carrier change and error (bit 15). It also raises clear-to-send.
- R6: In modem mode, a write that lowers DTR while connected pulses `hangup_o` and drops the connection. If carrier detect was set, it sets carrier change and error. In modem mode a falling DTR always clears carrier detect, ring and clear-to-send.
- R7: A connect in modem mode sets carrier detect, carrier change and error when DTR is 1, and sets ring and error when DTR is 0. Clear-to-send is not changed.
- R8: A connect in hardwired mode raises clear-to-send and leaves the status word unchanged.
- R9: A disconnect in modem mode with carrier detect set sets carrier change and error. Every disconnect clears carrier detect, ring and clear-to-send.
- R10: A character arriving while connected sets DONE, or sets overrun if DONE is already 1. It loads bit 5 with 1 when the character holds an odd number of ones. A character arriving while not connected is ignored.
- R11: `irq_o` pulses for one cycle, when IE is 1 after the event, for a received character, a modem connect, a modem carrier change from DTR or disconnect, and a DTR rise in modem mode. It also pulses for a write that turns IE on while DONE is 1 and IE was 0.
- R12: In hardwired mode, DTR writes never request a hangup and never change clear-to-send, carrier detect or ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modem_mode | input | 1 | 1 selects the dataset handshake, 0 selects hardwired |
| wr_en | input | 1 | CPU write strobe |
| wr_byte | input | 1 | 1 for a byte write, 0 for a word write |
| wr_hi | input | 1 | Byte lane select: 1 for the high byte |
| wr_data | input | 16 | Write data (the byte is in bits 7:0 for byte writes) |
| rd_en | input | 1 | CPU read strobe that clears status |
| conn_evt | input | 1 | Caller connected |
| disc_evt | input | 1 | Caller dropped |
| char_evt | input | 1 | Character received |
| char_data | input | CHAR_W | Received character |
| rd_data | output | 16 | Word captured by the last read |
| irq_o | output | 1 | One-cycle interrupt request |
| hangup_o | output | 1 | One-cycle request to hang up the line |
| cts_o | output | 1 | Clear-to-send toward the transmit side |

## Verification
The assertions take for granted that at most one of `wr_en`, `rd_en`, `conn_evt`, `disc_evt` and `char_evt` is high in a cycle, and that `modem_mode` stays steady around an event. Under those conditions each check can tie one cause to one effect. The stimulus walks one operation per cycle with idle check steps in between, and it changes the mode only between events. The fixed ordering of simultaneous inputs is still defined in the RTL, but the bench does not stress it.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int REG_W = 16;

  // bit positions of the status word
  localparam int B_DTR  = 0;
  localparam int B_BRK  = 1;
  localparam int B_CD   = 2;
  localparam int B_PAR  = 5;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;
  localparam int B_OVR  = 12;
  localparam int B_RING = 13;
  localparam int B_CCH  = 14;
  localparam int B_ERR  = 15;

  localparam logic [REG_W-1:0] RD_MASK  = 16'o173777;
  localparam logic [REG_W-1:0] WR_MASK  = 16'o003533;
  localparam logic [REG_W-1:0] CLR_MASK = (REG_W'(1) << B_DONE) | (REG_W'(1) << B_OVR) |
                                          (REG_W'(1) << B_RING) | (REG_W'(1) << B_CCH) |
                                          (REG_W'(1) << B_ERR);

  typedef struct packed {
    logic [REG_W-1:0] csr;
    logic             cts;
    logic             conn;
    logic             irq;
    logic             hup;
  } rsr_st_t;
endpackage

// File: rtl/rsr_wr_stage.sv
module rsr_wr_stage
  import rsr_pkg::*;
(
  input  rsr_st_t          st_i,
  input  logic             wr_en,
  input  logic             wr_byte,
  input  logic             wr_hi,
  input  logic [REG_W-1:0] wr_data,
  input  logic             modem,
  output rsr_st_t          st_o
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] merged;

  always_comb begin
    merged = wr_data;
    if (wr_byte) begin
      if (wr_hi) merged = {wr_data[HALF-1:0], st_i.csr[HALF-1:0]};
      else       merged = {st_i.csr[REG_W-1:HALF], wr_data[HALF-1:0]};
    end
  end

  always_comb begin
    st_o = st_i;
    if (wr_en) begin
      // enabling interrupts with a pending completion
      if (merged[B_IE] && !st_i.csr[B_IE] && st_i.csr[B_DONE])
        st_o.irq = 1'b1;
      if (modem && (merged[B_DTR] != st_i.csr[B_DTR])) begin
        if (merged[B_DTR]) begin
          if (st_i.conn) begin
            st_o.csr[B_RING] = 1'b0;
            st_o.csr[B_CD]   = 1'b1;
            st_o.csr[B_CCH]  = 1'b1;
            st_o.csr[B_ERR]  = 1'b1;
            st_o.cts         = 1'b1;
            if (merged[B_IE]) st_o.irq = 1'b1;
          end
        end else begin
          if (st_i.conn) begin
            st_o.hup  = 1'b1;
            st_o.conn = 1'b0;
            if (st_i.csr[B_CD]) begin
              st_o.csr[B_CCH] = 1'b1;
              st_o.csr[B_ERR] = 1'b1;
              if (merged[B_IE]) st_o.irq = 1'b1;
            end
          end
          st_o.csr[B_CD]   = 1'b0;
          st_o.csr[B_RING] = 1'b0;
          st_o.cts         = 1'b0;
        end
      end
      st_o.csr = (st_o.csr & ~WR_MASK) | (merged & WR_MASK);
    end
  end
endmodule

// File: rtl/rsr_line_stage.sv
module rsr_line_stage
  import rsr_pkg::*;
(
  input  rsr_st_t st_i,
  input  logic    conn_evt,
  input  logic    disc_evt,
  input  logic    modem,
  output rsr_st_t st_o
);
  always_comb begin
    st_o = st_i;
    if (conn_evt) begin
      st_o.conn = 1'b1;
      if (modem) begin
        if (st_i.csr[B_DTR]) begin
          st_o.csr[B_CD]  = 1'b1;
          st_o.csr[B_CCH] = 1'b1;
        end else begin
          st_o.csr[B_RING] = 1'b1;
        end
        st_o.csr[B_ERR] = 1'b1;
        if (st_i.csr[B_IE]) st_o.irq = 1'b1;
      end else begin
        st_o.cts = 1'b1;
      end
    end
    if (disc_evt) begin
      st_o.conn = 1'b0;
      if (modem && st_o.csr[B_CD]) begin
        st_o.csr[B_CCH] = 1'b1;
        st_o.csr[B_ERR] = 1'b1;
        if (st_o.csr[B_IE]) st_o.irq = 1'b1;
      end
      st_o.csr[B_CD]   = 1'b0;
      st_o.csr[B_RING] = 1'b0;
      st_o.cts         = 1'b0;
    end
  end
endmodule

// File: rtl/rsr_rx_stage.sv
module rsr_rx_stage
  import rsr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  rsr_st_t           st_i,
  input  logic              char_evt,
  input  logic [CHAR_W-1:0] char_data,
  output rsr_st_t           st_o
);
  logic odd_ones;
  assign odd_ones = ^char_data;

  always_comb begin
    st_o = st_i;
    if (char_evt && st_i.conn) begin
      if (st_i.csr[B_DONE]) st_o.csr[B_OVR]  = 1'b1;
      else                  st_o.csr[B_DONE] = 1'b1;
      st_o.csr[B_PAR] = odd_ones;
      if (st_i.csr[B_IE]) st_o.irq = 1'b1;
    end
  end
endmodule

// File: rtl/rsr_rd_stage.sv
module rsr_rd_stage
  import rsr_pkg::*;
(
  input  rsr_st_t          st_i,
  input  logic             rd_en,
  output rsr_st_t          st_o,
  output logic [REG_W-1:0] rd_val
);
  always_comb begin
    rd_val        = st_i.csr;
    rd_val[B_ERR] = st_i.csr[B_OVR] | st_i.csr[B_RING] | st_i.csr[B_CCH];
    rd_val        = rd_val & RD_MASK;
    st_o          = st_i;
    if (rd_en) st_o.csr = st_i.csr & ~CLR_MASK;
  end
endmodule

// File: rtl/rx_status_reg.sv
module rx_status_reg
  import rsr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modem_mode,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic              wr_hi,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic              conn_evt,
  input  logic              disc_evt,
  input  logic              char_evt,
  input  logic [CHAR_W-1:0] char_data,
  output logic [15:0]       rd_data,
  output logic              irq_o,
  output logic              hangup_o,
  output logic              cts_o
);
  logic [REG_W-1:0] csr_q;
  logic             conn_q;
  logic             cts_q;
  logic [REG_W-1:0] rd_q;
  logic             irq_q;
  logic             hup_q;

  rsr_st_t st_cur, st_wr, st_line, st_rx, st_rd;
  logic [REG_W-1:0] rd_val;

  always_comb begin
    st_cur.csr  = csr_q;
    st_cur.cts  = cts_q;
    st_cur.conn = conn_q;
    st_cur.irq  = 1'b0;
    st_cur.hup  = 1'b0;
  end

  rsr_wr_stage u_wr (
    .st_i(st_cur), .wr_en(wr_en), .wr_byte(wr_byte), .wr_hi(wr_hi),
    .wr_data(wr_data), .modem(modem_mode), .st_o(st_wr)
  );

  rsr_line_stage u_line (
    .st_i(st_wr), .conn_evt(conn_evt), .disc_evt(disc_evt),
    .modem(modem_mode), .st_o(st_line)
  );

  rsr_rx_stage #(.CHAR_W(CHAR_W)) u_rx (
    .st_i(st_line), .char_evt(char_evt), .char_data(char_data), .st_o(st_rx)
  );

  rsr_rd_stage u_rd (
    .st_i(st_rx), .rd_en(rd_en), .st_o(st_rd), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q  <= '0;
      conn_q <= 1'b0;
      cts_q  <= 1'b0;
      rd_q   <= '0;
      irq_q  <= 1'b0;
      hup_q  <= 1'b0;
    end else begin
      csr_q  <= st_rd.csr;
      conn_q <= st_rd.conn;
      cts_q  <= st_rd.cts;
      irq_q  <= st_rd.irq;
      hup_q  <= st_rd.hup;
      if (rd_en) rd_q <= rd_val;
    end
  end

  assign rd_data  = rd_q;
  assign irq_o    = irq_q;
  assign hangup_o = hup_q;
  assign cts_o    = cts_q;
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker
  import rsr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             modem_mode,
  input logic             wr_en,
  input logic             wr_byte,
  input logic [15:0]      wr_data,
  input logic             rd_en,
  input logic             conn_evt,
  input logic             disc_evt,
  input logic             char_evt,
  input logic             irq_o,
  input logic             hangup_o,
  input logic             cts_o,
  input logic [REG_W-1:0] csr_q,
  input logic             conn_q
);
  logic quiet_other;
  assign quiet_other = !conn_evt && !disc_evt && !char_evt && !wr_en;

  p_wr_mask_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_byte |=> ((csr_q & WR_MASK) == ($past(wr_data) & WR_MASK)));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en && quiet_other |=> ((csr_q & CLR_MASK) == '0));

  p_hangup_drops_line_r6: assert property (@(posedge clk) disable iff (rst)
    hangup_o |-> (!cts_o && !conn_q));

  p_hardwired_cts_r8: assert property (@(posedge clk) disable iff (rst)
    !modem_mode && conn_evt && !disc_evt && !wr_en |=> cts_o);

  p_disc_clears_r9: assert property (@(posedge clk) disable iff (rst)
    disc_evt |=> (!cts_o && !csr_q[B_CD] && !csr_q[B_RING]));

  p_overrun_r10: assert property (@(posedge clk) disable iff (rst)
    char_evt && conn_q && csr_q[B_DONE] && !rd_en && !disc_evt |=> csr_q[B_OVR]);

  p_irq_needs_ie_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> csr_q[B_IE]);

  p_no_hangup_hardwired_r12: assert property (@(posedge clk) disable iff (rst)
    !modem_mode && wr_en |=> !hangup_o);
endmodule

bind rx_status_reg rsr_checker u_chk (
  .clk(clk), .rst(rst), .modem_mode(modem_mode), .wr_en(wr_en), .wr_byte(wr_byte),
  .wr_data(wr_data), .rd_en(rd_en), .conn_evt(conn_evt), .disc_evt(disc_evt),
  .char_evt(char_evt), .irq_o(irq_o), .hangup_o(hangup_o), .cts_o(cts_o),
  .csr_q(csr_q), .conn_q(conn_q)
);

// File: tb/tb_rx_status_reg.sv
`timescale 1ns/1ps
module tb_rx_status_reg;
  localparam logic [3:0] OP_WW = 4'd1, OP_WL = 4'd2, OP_WH = 4'd3, OP_CONN = 4'd4,
                         OP_DISC = 4'd5, OP_CHAR = 4'd6, OP_READ = 4'd7, OP_MODE = 4'd8,
                         OP_CRD = 4'd9, OP_CCTS = 4'd10, OP_CIRQ = 4'd11, OP_CHUP = 4'd12;
  localparam int NV = 64;

  // {op, requirement number, argument, expected}
  localparam logic [39:0] TBL [NV] = '{
    // R2 word write mask
    {OP_WW, 4'd2, 16'hFFFF, 16'h0}, {OP_READ, 4'd2, 16'h0, 16'h0}, {OP_CRD, 4'd2, 16'h0, 16'h075B},
    // R3 byte lanes
    {OP_WL, 4'd3, 16'h0000, 16'h0}, {OP_READ, 4'd3, 16'h0, 16'h0}, {OP_CRD, 4'd3, 16'h0, 16'h0700},
    {OP_WH, 4'd3, 16'h0002, 16'h0}, {OP_READ, 4'd3, 16'h0, 16'h0}, {OP_CRD, 4'd3, 16'h0, 16'h0200},
    {OP_WW, 4'd11, 16'h0000, 16'h0}, {OP_CIRQ, 4'd11, 16'h0, 16'h0},
    // R10 character while not connected is ignored
    {OP_CHAR, 4'd10, 16'h0041, 16'h0}, {OP_READ, 4'd10, 16'h0, 16'h0}, {OP_CRD, 4'd10, 16'h0, 16'h0000},
    // R8 hardwired connect
    {OP_CONN, 4'd8, 16'h0, 16'h0}, {OP_CCTS, 4'd8, 16'h0, 16'h0001},
    {OP_READ, 4'd8, 16'h0, 16'h0}, {OP_CRD, 4'd8, 16'h0, 16'h0000},
    // R10 done, parity, overrun; R4 error summary and clearing
    {OP_CHAR, 4'd10, 16'h0041, 16'h0}, {OP_READ, 4'd10, 16'h0, 16'h0}, {OP_CRD, 4'd10, 16'h0, 16'h0080},
    {OP_CHAR, 4'd10, 16'h0043, 16'h0}, {OP_CHAR, 4'd10, 16'h0043, 16'h0},
    {OP_READ, 4'd4, 16'h0, 16'h0}, {OP_CRD, 4'd4, 16'h0, 16'h90A0},
    {OP_READ, 4'd4, 16'h0, 16'h0}, {OP_CRD, 4'd4, 16'h0, 16'h0020},
    // R11 interrupts on receive and on enabling with pending done
    {OP_WW, 4'd11, 16'h0040, 16'h0}, {OP_CHAR, 4'd11, 16'h0000, 16'h0}, {OP_CIRQ, 4'd11, 16'h0, 16'h0001},
    {OP_READ, 4'd11, 16'h0, 16'h0}, {OP_CRD, 4'd11, 16'h0, 16'h00C0},
    {OP_WW, 4'd11, 16'h0000, 16'h0}, {OP_CHAR, 4'd11, 16'h0001, 16'h0}, {OP_WW, 4'd11, 16'h0040, 16'h0},
    {OP_CIRQ, 4'd11, 16'h0, 16'h0001}, {OP_READ, 4'd11, 16'h0, 16'h0}, {OP_CRD, 4'd11, 16'h0, 16'h00E0},
    // R12 hardwired DTR toggles
    {OP_WW, 4'd12, 16'h0041, 16'h0}, {OP_WW, 4'd12, 16'h0040, 16'h0}, {OP_CHUP, 4'd12, 16'h0, 16'h0000},
    {OP_CCTS, 4'd12, 16'h0, 16'h0001}, {OP_CIRQ, 4'd12, 16'h0, 16'h0000},
    // R9 hardwired disconnect
    {OP_DISC, 4'd9, 16'h0, 16'h0}, {OP_CCTS, 4'd9, 16'h0, 16'h0000},
    {OP_READ, 4'd9, 16'h0, 16'h0}, {OP_CRD, 4'd9, 16'h0, 16'h0060},
    // R7 ringing connect, R5 DTR rise answers
    {OP_MODE, 4'd7, 16'h0001, 16'h0}, {OP_CONN, 4'd7, 16'h0, 16'h0}, {OP_CCTS, 4'd7, 16'h0, 16'h0000},
    {OP_WW, 4'd5, 16'h0041, 16'h0}, {OP_CIRQ, 4'd5, 16'h0, 16'h0002}, {OP_CCTS, 4'd5, 16'h0, 16'h0001},
    {OP_READ, 4'd5, 16'h0, 16'h0}, {OP_CRD, 4'd5, 16'h0, 16'hC065},
    // R6 DTR fall hangs up
    {OP_WW, 4'd6, 16'h0040, 16'h0}, {OP_CHUP, 4'd6, 16'h0, 16'h0001}, {OP_CCTS, 4'd6, 16'h0, 16'h0000},
    {OP_CIRQ, 4'd6, 16'h0, 16'h0001}, {OP_READ, 4'd6, 16'h0, 16'h0}, {OP_CRD, 4'd6, 16'h0, 16'hC060},
    // R10 after hangup the line is disconnected
    {OP_CHAR, 4'd10, 16'h0055, 16'h0}, {OP_READ, 4'd10, 16'h0, 16'h0}, {OP_CRD, 4'd10, 16'h0, 16'h0060}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modem_mode = 1'b0;
  logic        wr_en = 1'b0, wr_byte = 1'b0, wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0, conn_evt = 1'b0, disc_evt = 1'b0, char_evt = 1'b0;
  logic [7:0]  char_data = '0;
  logic [15:0] rd_data;
  logic        irq_o, hangup_o, cts_o;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, hup_cnt = 0;

  always #4 clk = ~clk;

  rx_status_reg dut (
    .clk(clk), .rst(rst), .modem_mode(modem_mode), .wr_en(wr_en), .wr_byte(wr_byte),
    .wr_hi(wr_hi), .wr_data(wr_data), .rd_en(rd_en), .conn_evt(conn_evt),
    .disc_evt(disc_evt), .char_evt(char_evt), .char_data(char_data),
    .rd_data(rd_data), .irq_o(irq_o), .hangup_o(hangup_o), .cts_o(cts_o)
  );

  always @(negedge clk) begin
    if (irq_o) irq_cnt = irq_cnt + 1;
    if (hangup_o) hup_cnt = hup_cnt + 1;
  end

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [3:0] req,
                       input logic [15:0] arg, input logic [15:0] exp);
    @(negedge clk);
    #1;
    wr_en = 0; wr_byte = 0; wr_hi = 0; rd_en = 0;
    conn_evt = 0; disc_evt = 0; char_evt = 0;
    case (op)
      OP_WW:   begin wr_en = 1; wr_data = arg; end
      OP_WL:   begin wr_en = 1; wr_byte = 1; wr_data = arg; end
      OP_WH:   begin wr_en = 1; wr_byte = 1; wr_hi = 1; wr_data = arg; end
      OP_CONN: conn_evt = 1;
      OP_DISC: disc_evt = 1;
      OP_CHAR: begin char_evt = 1; char_data = arg[7:0]; end
      OP_READ: rd_en = 1;
      OP_MODE: modem_mode = arg[0];
      OP_CRD:  check(int'(req), rd_data, exp);
      OP_CCTS: check(int'(req), {15'b0, cts_o}, exp);
      OP_CIRQ: begin check(int'(req), 16'(irq_cnt), exp); irq_cnt = 0; end
      OP_CHUP: begin check(int'(req), 16'(hup_cnt), exp); hup_cnt = 0; end
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 state after reset
    @(negedge clk); #1;
    check(1, rd_data, 16'h0000);
    check(1, {14'b0, cts_o, irq_o}, 16'h0000);
    irq_cnt = 0; hup_cnt = 0;

    for (int i = 0; i < NV; i++)
      do_op(TBL[i][39:36], TBL[i][35:32], TBL[i][31:16], TBL[i][15:0]);

    // R7 connect with DTR already high (modem, not connected, IE set)
    do_op(OP_WW, 4'd7, 16'h0041, 16'h0);
    do_op(OP_CHUP, 4'd7, 16'h0, 16'h0000);
    do_op(OP_CONN, 4'd7, 16'h0, 16'h0);
    do_op(OP_CCTS, 4'd7, 16'h0, 16'h0000);
    do_op(OP_CIRQ, 4'd7, 16'h0, 16'h0001);
    do_op(OP_READ, 4'd7, 16'h0, 16'h0);
    do_op(OP_CRD, 4'd7, 16'h0, 16'hC065);
    // R9 disconnect with carrier detect
    do_op(OP_DISC, 4'd9, 16'h0, 16'h0);
    do_op(OP_CIRQ, 4'd9, 16'h0, 16'h0001);
    do_op(OP_READ, 4'd9, 16'h0, 16'h0);
    do_op(OP_CRD, 4'd9, 16'h0, 16'hC061);
    // R4 ring dropped by disconnect: stored error not reported
    do_op(OP_WW, 4'd4, 16'h0040, 16'h0);
    do_op(OP_CONN, 4'd4, 16'h0, 16'h0);
    do_op(OP_DISC, 4'd4, 16'h0, 16'h0);
    do_op(OP_CIRQ, 4'd4, 16'h0, 16'h0001);
    do_op(OP_READ, 4'd4, 16'h0, 16'h0);
    do_op(OP_CRD, 4'd4, 16'h0, 16'h0060);
    // R1 reset in the middle of a call
    do_op(OP_CONN, 4'd1, 16'h0, 16'h0);
    do_op(OP_READ, 4'd1, 16'h0, 16'h0);
    @(negedge clk); #1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(1, rd_data, 16'h0000);
    check(1, {15'b0, cts_o}, 16'h0000);
    rst = 1'b0;
    do_op(OP_READ, 4'd1, 16'h0, 16'h0);
    do_op(OP_CRD, 4'd1, 16'h0, 16'h0000);
    do_op(OP_CHAR, 4'd1, 16'h0033, 16'h0);
    do_op(OP_READ, 4'd1, 16'h0, 16'h0);
    do_op(OP_CRD, 4'd1, 16'h0, 16'h0000);
    finish_run();
  end
endmodule